// File: doc/BRIEF.md
# Host-Bus Control and CPU Reset Register

This block is one memory-mapped control register that sits in a media processor's bus interface. An external host writes it through a simple single-cycle write port. The register decides whether the on-chip image-capture engine may use the external PCI bus to move pixel data. It also decides whether the embedded CPU may take the host role on that bus, and it holds the embedded CPU and its instruction cache in reset or lets them run. The data cache and the peripherals are never affected by this reset.

A further stored bit chooses the PCI read command that a bus read transaction presents. DMA reads normally use the memory-read-multiple command. Setting the bit forces them down to plain memory-read, which is the command that CPU reads of PCI space always use. The reset control is write-one-to-act: a 1 in the assert field or in the release field changes the reset line, and a 0 in either field leaves it alone. Neither field keeps a value for readback.

Top module: `hbc_ctrl_reg`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the following edge leaves `cap_dma_en`=0 and the stored host-enable=0. It also leaves the read-multiple-disable bit=0, `cpu_rst`=1 and `rd_data`=0.
- R2: A write (`wr_en`=1) stores `wr_data[0]` as the capture enable. `cap_dma_en` equals the stored value from the edge after the write onward.
- R3: The stored host-enable bit is written from `wr_data[1]`. `host_mode` is 1 only while that stored bit is 1 and `cfg_master_en` is 1 in the same cycle.
- R4: A write with `wr_data[3]`=1 sets `cpu_rst` to 1 at that edge. A write with `wr_data[3]`=0 and `wr_data[2]`=0 leaves `cpu_rst` unchanged.
- R5: A write with `wr_data[2]`=1 and `wr_data[3]`=0 clears `cpu_rst` to 0 at that edge.
- R6: A write with both `wr_data[3]` and `wr_data[2]` equal to 1 leaves `cpu_rst`=1, because assert wins over release.
- R7: The stored read-multiple-disable bit is written from `wr_data[4]`. `rd_cmd` is 4'b1100 when `xact_is_dma`=1 and that bit is 0. In every other case `rd_cmd` is 4'b0110.
- R8: `rd_data` shows the stored capture enable in bit 0, host-enable in bit 1 and read-multiple-disable in bit 4. Bits 2 and 3 and all other bits read 0.
- R9: A cycle with `wr_en`=0 changes none of the stored bits or `cpu_rst`, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe from the host port |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Readback value of the register |
| cfg_master_en | input | 1 | Bus-master enable from the configuration command register |
| xact_is_dma | input | 1 | Current read transaction comes from DMA (1) or from the CPU (0) |
| cap_dma_en | output | 1 | Capture engine may request the PCI bus |
| host_mode | output | 1 | Embedded CPU may act as PCI host |
| cpu_rst | output | 1 | Reset to the embedded CPU and its instruction cache |
| rd_cmd | output | 4 | PCI read command code for the current transaction |

## Verification
The reset field pair is driven with all four combinations of assert and release. This separates set-wins priority from release-wins priority and from a design that treats a written 0 as an action. The bench toggles `cfg_master_en` both with host-enable stored high and with it stored low, so an OR gate cannot pass for an AND gate. The command selector is tried with all four pairings of transaction source and disable bit. Writes with `wr_en` low carry all-ones and all-zero data, which exposes any path that does not respect the strobe. A long pseudo-random write stream then runs against a behavioural model that is compared on every clock.

// File: rtl/hbc_pkg.sv
// Package: field positions and bus command codes shared by the control register.
// Assumes: the field positions below are the software-visible layout.
package hbc_pkg;
    localparam int unsigned FLD_CAP  = 0;
    localparam int unsigned FLD_HOST = 1;
    localparam int unsigned FLD_REL  = 2;
    localparam int unsigned FLD_ASRT = 3;
    localparam int unsigned FLD_RMD  = 4;
    localparam int unsigned FLD_MIN_W = 5;

    typedef enum logic [3:0] {
        CMD_MEM_RD      = 4'b0110,
        CMD_MEM_RD_MULT = 4'b1100
    } bus_cmd_e;

    typedef struct packed {
        logic cap;
        logic host;
        logic rmd;
    } ctrl_bits_t;
endpackage

// File: rtl/hbc_field_store.sv
// Module: stores the plain read/write control fields.
// Assumes: a write replaces every stored field at once; synchronous active-low reset.
module hbc_field_store
    import hbc_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_bits_t       bits
);
    // Update the stored fields on a host write; clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (wr_en) begin
            bits.cap  <= wr_data[FLD_CAP];
            bits.host <= wr_data[FLD_HOST];
            bits.rmd  <= wr_data[FLD_RMD];
        end
    end
endmodule

// File: rtl/hbc_cpu_reset.sv
// Module: write-one-to-act reset line for the embedded CPU and instruction cache.
// Assumes: the assert field has priority over the release field; the line is high after power-on reset.
module hbc_cpu_reset #(
    parameter bit ASSERT_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic asrt_bit,
    input  logic rel_bit,
    output logic cpu_rst
);
    logic do_set;
    logic do_clr;

    // Decode the two action bits into set and clear with the chosen priority.
    generate
        if (ASSERT_WINS) begin : g_set_first
            always_comb begin
                do_set = wr_en && asrt_bit;
                do_clr = wr_en && rel_bit && !asrt_bit;
            end
        end else begin : g_clr_first
            always_comb begin
                do_clr = wr_en && rel_bit;
                do_set = wr_en && asrt_bit && !rel_bit;
            end
        end
    endgenerate

    // Hold, set or clear the reset line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rst <= 1'b1;
        end else if (do_set) begin
            cpu_rst <= 1'b1;
        end else if (do_clr) begin
            cpu_rst <= 1'b0;
        end
    end
endmodule

// File: rtl/hbc_cmd_sel.sv
// Module: picks the PCI read command for the transaction under way.
// Assumes: DMA reads may burst unless disabled; CPU reads are always single.
module hbc_cmd_sel
    import hbc_pkg::*;
(
    input  logic       xact_is_dma,
    input  logic       rmd,
    output logic [3:0] rd_cmd
);
    bus_cmd_e cmd;

    // Choose between the burst and single read commands.
    always_comb begin
        if (xact_is_dma && !rmd) cmd = CMD_MEM_RD_MULT;
        else                     cmd = CMD_MEM_RD;
        rd_cmd = cmd;
    end
endmodule

// File: rtl/hbc_ctrl_reg.sv
// Module: top of the host-bus control register. It combines the stored fields,
// the CPU reset line, the command selector and the readback word.
// Assumes: REG_W >= 5; writes are single-cycle strobes from the host port.
module hbc_ctrl_reg
    import hbc_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             cfg_master_en,
    input  logic             xact_is_dma,
    output logic             cap_dma_en,
    output logic             host_mode,
    output logic             cpu_rst,
    output logic [3:0]       rd_cmd
);
    localparam int unsigned PAD_W = REG_W - FLD_MIN_W;

    ctrl_bits_t bits;

    hbc_field_store #(.REG_W(REG_W)) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bits    (bits)
    );

    hbc_cpu_reset #(.ASSERT_WINS(1'b1)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .asrt_bit (wr_data[FLD_ASRT]),
        .rel_bit  (wr_data[FLD_REL]),
        .cpu_rst  (cpu_rst)
    );

    hbc_cmd_sel u_cmd (
        .xact_is_dma (xact_is_dma),
        .rmd         (bits.rmd),
        .rd_cmd      (rd_cmd)
    );

    // Drive the bus grant outputs from the stored fields.
    always_comb begin
        cap_dma_en = bits.cap;
        host_mode  = bits.host && cfg_master_en;
    end

    // Assemble the readback word; action fields read as zero.
    always_comb begin
        rd_data = {{PAD_W{1'b0}}, bits.rmd, 1'b0, 1'b0, bits.host, bits.cap};
    end
endmodule

// File: rtl/hbc_ctrl_reg_chk.sv
// Checker: temporal properties of the control register, bound to the top.
module hbc_ctrl_reg_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             cfg_master_en,
    input logic             xact_is_dma,
    input logic             cap_dma_en,
    input logic             host_mode,
    input logic             cpu_rst,
    input logic [3:0]       rd_cmd
);
    p_reset_state_r1: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (cpu_rst && rd_data == '0 && !cap_dma_en));

    p_host_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode |-> (cfg_master_en && rd_data[1]));

    p_assert_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3]) |=> cpu_rst);

    p_release_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2] && !wr_data[3]) |=> !cpu_rst);

    p_burst_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_is_dma && !rd_data[4]) |-> (rd_cmd == 4'b1100));

    p_cpu_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xact_is_dma |-> (rd_cmd == 4'b0110));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_data) && $stable(cpu_rst)));
endmodule

bind hbc_ctrl_reg hbc_ctrl_reg_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_hbc_ctrl_reg.sv
module sim_hbc_ctrl_reg;
    localparam int REG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic             cfg_master_en = 1'b0;
    logic             xact_is_dma = 1'b0;
    logic [REG_W-1:0] rd_data;
    logic             cap_dma_en;
    logic             host_mode;
    logic             cpu_rst;
    logic [3:0]       rd_cmd;

    int vectors = 0;
    int miscompares = 0;

    // Behavioural reference state
    bit m_cap, m_host, m_rmd, m_rst;

    always #5 clk = ~clk;

    hbc_ctrl_reg #(.REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cfg_master_en(cfg_master_en),
        .xact_is_dma(xact_is_dma), .cap_dma_en(cap_dma_en),
        .host_mode(host_mode), .cpu_rst(cpu_rst), .rd_cmd(rd_cmd)
    );

    // Reference model updated at each edge from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cap <= 0; m_host <= 0; m_rmd <= 0; m_rst <= 1;
        end else if (wr_en) begin
            m_cap  <= wr_data[0];
            m_host <= wr_data[1];
            m_rmd  <= wr_data[4];
            if (wr_data[3])      m_rst <= 1;
            else if (wr_data[2]) m_rst <= 0;
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, then compare one cycle later at the next falling edge
    task automatic step(input bit rn, input bit we, input logic [REG_W-1:0] d,
                        input bit cfg, input bit dma, input string tag);
        logic [REG_W-1:0] exp_rd;
        rst_n = rn; wr_en = we; wr_data = d; cfg_master_en = cfg; xact_is_dma = dma;
        @(negedge clk);
        exp_rd = '0;
        exp_rd[0] = m_cap; exp_rd[1] = m_host; exp_rd[4] = m_rmd;
        cmp(tag, "rd_data", int'(rd_data), int'(exp_rd));
        cmp(tag, "cap_dma_en", int'(cap_dma_en), int'(m_cap));
        cmp(tag, "host_mode", int'(host_mode), int'(m_host && cfg));
        cmp(tag, "cpu_rst", int'(cpu_rst), int'(m_rst));
        cmp(tag, "rd_cmd", int'(rd_cmd), (dma && !m_rmd) ? 32'hC : 32'h6);
    endtask

    initial begin
        int unsigned lfsr;
        @(negedge clk);
        // R1: reset with junk data on the write port
        step(0, 1, 32'hFFFF_FFEB, 1, 1, "R1");
        step(0, 0, 32'h0, 0, 0, "R1");
        if (cpu_rst !== 1'b1 || rd_data !== '0) begin
            miscompares++;
            $display("FAIL R1 direct actual=%0h/%0h expected=1/0", cpu_rst, rd_data);
        end
        vectors++;
        // R9: idle cycles with all-ones and zero data
        step(1, 0, 32'hFFFF_FFFF, 1, 1, "R9");
        step(1, 0, 32'h0000_0004, 1, 0, "R9");
        // R2: capture enable on and off
        step(1, 1, 32'h0000_0001, 0, 0, "R2");
        step(1, 0, 32'h0, 0, 0, "R2");
        step(1, 1, 32'h0000_0000, 0, 0, "R2");
        // R3: host enable with master enable toggling
        step(1, 1, 32'h0000_0002, 0, 0, "R3");
        step(1, 0, 32'h0, 1, 0, "R3");
        step(1, 0, 32'h0, 0, 0, "R3");
        step(1, 1, 32'h0000_0000, 1, 0, "R3");
        step(1, 0, 32'h0, 1, 0, "R3");
        // R5: release, then R4 zero writes keep it released, then assert
        step(1, 1, 32'h0000_0004, 0, 0, "R5");
        step(1, 1, 32'h0000_0013, 1, 1, "R4");
        step(1, 1, 32'h0000_0008, 0, 0, "R4");
        step(1, 1, 32'h0000_0000, 0, 0, "R4");
        // R6: both action bits while asserted, and after a release
        step(1, 1, 32'h0000_000C, 0, 0, "R6");
        step(1, 1, 32'h0000_0004, 0, 0, "R5");
        step(1, 1, 32'h0000_000C, 0, 0, "R6");
        // R7: all pairings of source and disable bit
        step(1, 1, 32'h0000_0000, 0, 1, "R7");
        step(1, 0, 32'h0, 0, 0, "R7");
        step(1, 1, 32'h0000_0010, 0, 1, "R7");
        step(1, 0, 32'h0, 0, 0, "R7");
        // R8: all-ones write; action and unused bits read zero
        step(1, 1, 32'hFFFF_FFFF, 1, 1, "R8");
        step(1, 1, 32'hFFFF_FFE0, 1, 1, "R8");
        // Mixed stream
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(1, lfsr[7], {lfsr[27:0], lfsr[31:28]}, lfsr[9], lfsr[11], "R9");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule